// File: doc/BRIEF.md
# Protection Fault Capture Unit

A protection checker sits in front of several slave ports and refuses some accesses. This unit sits beside it, with one capture slot for each port. When the checker pulses a deny for a port, the slot stores the offending address. It also stores a detail word that describes the access: who made it, its attribute code, its direction and which region descriptors matched. The slot also reduces the match vector to a class code, so software can tell three cases apart at a glance: nothing matched, one region matched, or regions overlapped.

Each port also owns a sticky flag. All the flags sit in one shared status word, together with read-only build constants. A flag freezes its slot until software clears it by writing a one to that flag. An error that arrives in the same cycle as the clear wins over the clear. The rights evaluation itself lives in the checker, not here.

Top module: `prot_err_capture`

## Requirements
- R1: After reset every flag is 0, and every captured address, detail word and class code reads 0.
- R2: A deny pulse on port p while its flag is clear stores the full access address in slot p. The stored value is visible on the cycle after the deny pulse.
- R3: The detail word of a slot is {hit vector, master number, attribute code, write flag}. The write flag sits at bit 0 and the attribute code just above it. The master number comes next, and the hit vector, with one bit per region descriptor, is the top field.
- R4: The class code of a slot is 0 when the captured hit vector is all zero. It is 1 when exactly one hit bit is set, and 2 when two or more hit bits are set.
- R5: In the status word, the flag of port p is bit 16 + (NUM_PORTS-1-p), so port 0 is the most significant flag. A deny pulse on a port sets its flag.
- R6: A clear strobe with a one in mask bit (NUM_PORTS-1-p) clears the flag of port p. A zero in that mask bit leaves the flag of port p unchanged.
- R7: While the flag of a port is set, further deny pulses on that port leave its address, detail and class unchanged.
- R8: When a deny pulse and a clear of the same port arrive in one cycle, the flag stays set and the new access is captured.
- R9: Status bits [7:0] hold NUM_REGIONS, bits [11:8] hold NUM_PORTS and bits [15:12] hold REV_LEVEL. Writes never change these fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deny_vld | input | NUM_PORTS | One-cycle deny pulse, one bit per port |
| deny_addr | input | NUM_PORTS*ADDR_W | Access address of each port |
| deny_master | input | NUM_PORTS*MASTER_W | Requesting master number of each port |
| deny_attr | input | NUM_PORTS*ATTR_W | Attribute code of each port |
| deny_write | input | NUM_PORTS | 1 = write access, one bit per port |
| deny_hits | input | NUM_PORTS*NUM_REGIONS | Matching region descriptors of each port |
| clr_wr | input | 1 | Write strobe to the flag field |
| clr_mask | input | NUM_PORTS | Written flag-field value; a one clears that flag |
| err_addr | output | NUM_PORTS*ADDR_W | Captured address of each port |
| err_detail | output | NUM_PORTS*DET_W | Captured detail word of each port |
| err_class | output | NUM_PORTS*2 | Hit class of each port |
| status | output | NUM_PORTS+16 | Flags and build constants |

## Verification
The assertions treat deny_vld as a per-cycle qualifier: the access fields of a port are taken to be meaningful only in a cycle where its deny bit is high. The assertions also take clr_mask to matter only while clr_wr is high. The stimulus never breaks these assumptions. Some cycles carry random denies on several ports and random clears together, some repeat denies on ports that are already flagged, and some deliberately put a deny and a clear of the same port in one cycle.

// File: rtl/prot_err_capture.sv
module prot_err_capture #(
  parameter int NUM_PORTS   = 4,
  parameter int ADDR_W      = 32,
  parameter int MASTER_W    = 4,
  parameter int ATTR_W      = 3,
  parameter int NUM_REGIONS = 8,
  parameter int REV_LEVEL   = 1,
  localparam int DET_W      = NUM_REGIONS + MASTER_W + ATTR_W + 1,
  localparam int ST_W       = NUM_PORTS + 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PORTS-1:0]            deny_vld,
  input  logic [NUM_PORTS*ADDR_W-1:0]     deny_addr,
  input  logic [NUM_PORTS*MASTER_W-1:0]   deny_master,
  input  logic [NUM_PORTS*ATTR_W-1:0]     deny_attr,
  input  logic [NUM_PORTS-1:0]            deny_write,
  input  logic [NUM_PORTS*NUM_REGIONS-1:0] deny_hits,
  input  logic                            clr_wr,
  input  logic [NUM_PORTS-1:0]            clr_mask,
  output logic [NUM_PORTS*ADDR_W-1:0]     err_addr,
  output logic [NUM_PORTS*DET_W-1:0]      err_detail,
  output logic [NUM_PORTS*2-1:0]          err_class,
  output logic [ST_W-1:0]                 status
);

  logic [NUM_PORTS-1:0] flag;
  logic [NUM_PORTS-1:0] flag_field;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [NUM_REGIONS-1:0] hits;
    logic                   clr_hit;
    logic                   take;
    logic [1:0]             cls;

    assign hits    = deny_hits[p*NUM_REGIONS +: NUM_REGIONS];
    assign clr_hit = clr_wr & clr_mask[NUM_PORTS-1-p];
    assign take    = deny_vld[p] & (~flag[p] | clr_hit);
    assign cls     = (hits == '0) ? 2'd0 :
                     ((hits & (hits - 1'b1)) == '0) ? 2'd1 : 2'd2;
    assign flag_field[NUM_PORTS-1-p] = flag[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag[p]                         <= 1'b0;
        err_addr[p*ADDR_W +: ADDR_W]    <= '0;
        err_detail[p*DET_W +: DET_W]    <= '0;
        err_class[p*2 +: 2]             <= 2'd0;
      end else begin
        if (deny_vld[p])  flag[p] <= 1'b1;
        else if (clr_hit) flag[p] <= 1'b0;
        if (take) begin
          err_addr[p*ADDR_W +: ADDR_W] <= deny_addr[p*ADDR_W +: ADDR_W];
          err_detail[p*DET_W +: DET_W] <= {hits,
                                           deny_master[p*MASTER_W +: MASTER_W],
                                           deny_attr[p*ATTR_W +: ATTR_W],
                                           deny_write[p]};
          err_class[p*2 +: 2]          <= cls;
        end
      end
    end

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      deny_vld[p] && !status[16+NUM_PORTS-1-p]
      |=> err_addr[p*ADDR_W +: ADDR_W] == $past(deny_addr[p*ADDR_W +: ADDR_W]));

    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      status[16+NUM_PORTS-1-p] && !(clr_wr && clr_mask[NUM_PORTS-1-p])
      |=> $stable(err_addr[p*ADDR_W +: ADDR_W]) && $stable(err_detail[p*DET_W +: DET_W]));

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr && clr_mask[NUM_PORTS-1-p] && !deny_vld[p]
      |=> !status[16+NUM_PORTS-1-p]);

    a_r8_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
      deny_vld[p] |=> status[16+NUM_PORTS-1-p]);

    a_r4_class_legal: assert property (@(posedge clk) disable iff (!rst_n)
      err_class[p*2 +: 2] != 2'd3);
  end

  assign status = {flag_field, 4'(REV_LEVEL), 4'(NUM_PORTS), 8'(NUM_REGIONS)};

  a_r9_consts: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(status[15:0]));

endmodule

// File: tb/tb_prot_err_capture.sv
`timescale 1ns/1ps
module tb_prot_err_capture;
  localparam int NP = 4, AW = 32, MW = 4, TW = 3, NR = 8, REV = 1;
  localparam int DW = NR + MW + TW + 1;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] deny_vld = '0, deny_write = '0, clr_mask = '0;
  logic [NP*AW-1:0] deny_addr = '0;
  logic [NP*MW-1:0] deny_master = '0;
  logic [NP*TW-1:0] deny_attr = '0;
  logic [NP*NR-1:0] deny_hits = '0;
  logic clr_wr = 0;
  logic [NP*AW-1:0] err_addr;
  logic [NP*DW-1:0] err_detail;
  logic [NP*2-1:0]  err_class;
  logic [NP+15:0]   status;

  prot_err_capture #(.NUM_PORTS(NP), .ADDR_W(AW), .MASTER_W(MW), .ATTR_W(TW),
                     .NUM_REGIONS(NR), .REV_LEVEL(REV)) dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic          mf [NP];
  logic [AW-1:0] ma [NP];
  logic [DW-1:0] md [NP];
  logic [1:0]    mc [NP];

  function automatic logic [1:0] hit_class(logic [NR-1:0] h);
    int n = 0;
    for (int i = 0; i < NR; i++) n += int'(h[i]);
    return (n == 0) ? 2'd0 : (n == 1) ? 2'd1 : 2'd2;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string ta, string tf);
    for (int p = 0; p < NP; p++) begin
      chk(err_addr[p*AW +: AW] == ma[p], ta, $sformatf("addr port %0d", p), 64'(err_addr[p*AW +: AW]), 64'(ma[p]));
      chk(err_detail[p*DW +: DW] == md[p], "R3", $sformatf("detail port %0d", p), 64'(err_detail[p*DW +: DW]), 64'(md[p]));
      chk(err_class[p*2 +: 2] == mc[p], "R4", $sformatf("class port %0d", p), 64'(err_class[p*2 +: 2]), 64'(mc[p]));
      chk(status[16+NP-1-p] == mf[p], tf, $sformatf("flag port %0d", p), 64'(status[16+NP-1-p]), 64'(mf[p]));
    end
    chk(status[15:0] == {4'(REV), 4'(NP), 8'(NR)}, "R9", "constants", 64'(status[15:0]), 64'({4'(REV), 4'(NP), 8'(NR)}));
  endtask

  task automatic apply(logic [NP-1:0] dv, logic [NP*AW-1:0] ad, logic [NP*MW-1:0] ms,
                       logic [NP*TW-1:0] at, logic [NP-1:0] wr, logic [NP*NR-1:0] hs,
                       logic cw, logic [NP-1:0] cm);
    deny_vld = dv; deny_addr = ad; deny_master = ms; deny_attr = at;
    deny_write = wr; deny_hits = hs; clr_wr = cw; clr_mask = cm;
    for (int p = 0; p < NP; p++) begin
      logic clr = cw && cm[NP-1-p];
      if (dv[p] && (!mf[p] || clr)) begin
        ma[p] = ad[p*AW +: AW];
        md[p] = {hs[p*NR +: NR], ms[p*MW +: MW], at[p*TW +: TW], wr[p]};
        mc[p] = hit_class(hs[p*NR +: NR]);
      end
      if (dv[p]) mf[p] = 1'b1;
      else if (clr) mf[p] = 1'b0;
    end
    @(negedge clk);
    deny_vld = '0; clr_wr = 0; clr_mask = '0;
  endtask

  function automatic logic [NR-1:0] rand_hits();
    int m = int'($urandom % 3);
    if (m == 0) return '0;
    if (m == 1) return NR'(1) << ($urandom % NR);
    return (NR'(1) << ($urandom % NR)) | (NR'(1) << (($urandom % (NR-1) + 1 + $urandom % 1) % NR)) | NR'($urandom);
  endfunction

  initial begin
    #(4*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NP*AW-1:0] a;
    logic [NP*MW-1:0] m;
    logic [NP*TW-1:0] t;
    logic [NP*NR-1:0] h;
    void'($urandom(32'd1234));
    for (int p = 0; p < NP; p++) begin mf[p] = 0; ma[p] = '0; md[p] = '0; mc[p] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1", "R1");

    // R2 R4: no hit, single hit, overlap, single
    a = {32'hDEAD_0003, 32'h8000_1002, 32'h4000_2001, 32'h1234_5670};
    m = {4'd3, 4'd2, 4'd1, 4'd0};
    t = {3'd7, 3'd5, 3'd2, 3'd1};
    h = {8'h80, 8'h12, 8'h04, 8'h00};
    apply(4'hF, a, m, t, 4'b1010, h, 0, '0);
    check_all("R2", "R5");

    // R7: repeat errors while flagged
    apply(4'hF, ~a, ~m, ~t, 4'b0101, ~h, 0, '0);
    check_all("R7", "R7");

    // R6: writing zeros changes nothing
    apply('0, a, m, t, '0, h, 1, 4'b0000);
    check_all("R7", "R6");

    // R6: clear port 0 (mask MSB)
    apply('0, a, m, t, '0, h, 1, 4'b1000);
    check_all("R6", "R6");

    // R8: error and clear of port 1 in one cycle
    apply(4'b0010, {4{32'hCAFE_F00D}}, m, t, 4'b0010, {4{8'h30}}, 1, 4'b0100);
    check_all("R8", "R8");

    for (int i = 0; i < 3000; i++) begin
      logic [NP-1:0] dv = '0, cm;
      for (int p = 0; p < NP; p++) begin
        dv[p] = ($urandom % 4) == 0;
        a[p*AW +: AW] = $urandom;
        h[p*NR +: NR] = rand_hits();
      end
      m = NP*MW'($urandom); t = NP*TW'($urandom); cm = NP'($urandom);
      apply(dv, a, m, t, NP'($urandom), h, ($urandom % 3) == 0, cm);
      check_all("R2", "R5");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule